// File: doc/BRIEF.md
# Four-Entry Pseudo-LRU Replacement Tracker

This block holds the replacement-order state of a small fully associative translation buffer (four entries by default). The state is one bit per unordered pair of entries, six bits for four entries. A bit at 1 means that the higher-numbered entry of its pair was used more recently than the lower one. Every hit on an entry, and every refill of the entry that the block itself names as the victim, rewrites only the bits of the pairs that contain that entry. The other bits keep their values.

The victim is the entry whose pair bits all say "the other entry is newer". The block decodes this from the stored state and presents it as a combinational output. A state in which no entry is oldest is reported on an error flag. The six bits also form a field of a larger control register. Software can load them directly, and they are brought out for read-back.

Each clock edge, the next state comes from exactly one of four sources: HOLD (keep the state), SW (software load), REFILL (mark the current victim as used) and HIT (mark the hit entry as used). The SW source has the highest priority, then REFILL, then HIT. A refill requested while the error flag is set selects HOLD.

Top module: `plru_tracker`

## Requirements
- R1: While reset is held low, and after it is released with no request, the state is 6'b000000, the victim is entry 3 and the error flag is 0.
- R2: A use of entry 0 clears state bits [5:3] and leaves bits [2:0] unchanged.
- R3: A use of entry 1 sets bit 5, clears bits 2 and 1, and leaves bits 4, 3 and 0 unchanged.
- R4: A use of entry 2 sets bits 4 and 2, clears bit 0, and leaves bits 5, 3 and 1 unchanged.
- R5: A use of entry 3 sets bits 3, 1 and 0, and leaves bits 5, 4 and 2 unchanged.
- R6: The victim is decoded with entry 0 checked first, then 1, 2 and 3:
  - entry 0 when bits [5:3] are all 1;
  - entry 1 when bit 5 is 0 and bits 2 and 1 are both 1;
  - entry 2 when bits 4 and 2 are 0 and bit 0 is 1;
  - entry 3 when bits 3, 1 and 0 are all 0.
  The victim output reads 0 whenever the error flag is set.
- R7: The error flag is 1 exactly when the state matches none of the four victim patterns.
- R8: A refill applies to the stored state the same update that a hit on the current victim would apply. A refill takes priority over a hit in the same cycle, and the hit is then dropped.
- R9: A refill requested while the error flag is 1 leaves the state unchanged, even when a hit is requested in the same cycle.
- R10: A software write loads all six bits from the write data. It overrides any refill or hit in the same cycle.
- R11: With no write, refill or hit, the state keeps its value.
- R12: Every state change takes effect at the clock edge that samples the request. The victim and error outputs follow the new state within that same cycle, with no further register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the state |
| hit_valid | input | 1 | An entry was hit this cycle |
| hit_idx | input | 2 | Index of the hit entry |
| refill_valid | input | 1 | The current victim is being refilled this cycle |
| sw_wr | input | 1 | Software load of the state field |
| sw_data | input | 6 | Value for a software load |
| lru_state | output | 6 | Stored state, for read-back |
| victim_idx | output | 2 | Entry to replace next |
| state_err | output | 1 | The stored state names no victim |

## Verification
Every request is sampled at one rising edge. The new state appears on `lru_state` right after that edge, and the victim and error outputs follow in the same cycle. The bench therefore drives each request on a falling edge and checks the results at the next falling edge, one edge later, never at a clock edge.

The bench visits all 64 states through software loads. For each state it checks the victim and error decode. It then applies a hit on each of the four entries and a refill, and compares the result with models written from the requirements. Same-cycle collisions between requests are checked in the cycle that follows them.

// File: rtl/plru_pkg.sv
package plru_pkg;

    // Source of the next state, one per kind of transition.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_SW     = 2'd1,
        SRC_REFILL = 2'd2,
        SRC_HIT    = 2'd3
    } plru_src_e;

    // Bit position of the pair (lo, hi), with lo < hi.
    // Pairs are counted in lexical order, and the first pair sits in the MSB.
    function automatic int pair_pos(input int n, input int lo, input int hi);
        int k;
        k = 0;
        for (int a = 0; a < lo; a++) begin
            k = k + (n - 1 - a);
        end
        k = k + (hi - lo - 1);
        return (n * (n - 1) / 2) - 1 - k;
    endfunction

endpackage

// File: rtl/plru_masks.sv
module plru_masks #(
    parameter int N  = 4,
    parameter int SW = N * (N - 1) / 2
) (
    output logic [N-1:0][SW-1:0] set_m,
    output logic [N-1:0][SW-1:0] clr_m
);
    import plru_pkg::*;

    // For a use of entry e: the pairs in which e is the higher entry get 1,
    // and the pairs in which e is the lower entry get 0.
    for (genvar e = 0; e < N; e++) begin : g_ent
        always_comb begin
            set_m[e] = '0;
            clr_m[e] = '0;
            for (int o = 0; o < N; o++) begin
                if (o < e) begin
                    set_m[e][pair_pos(N, o, e)] = 1'b1;
                end else if (o > e) begin
                    clr_m[e][pair_pos(N, e, o)] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/plru_victim_dec.sv
module plru_victim_dec #(
    parameter int N  = 4,
    parameter int SW = N * (N - 1) / 2,
    parameter int IW = $clog2(N)
) (
    input  logic [SW-1:0]        state,
    input  logic [N-1:0][SW-1:0] set_m,
    input  logic [N-1:0][SW-1:0] clr_m,
    output logic [IW-1:0]        victim,
    output logic                 err
);
    logic [N-1:0] oldest;

    // Entry e is oldest when every one of its pair bits holds the value
    // that a use of e would overwrite.
    for (genvar e = 0; e < N; e++) begin : g_match
        assign oldest[e] = ((state & (set_m[e] | clr_m[e])) == clr_m[e]);
    end

    // Lowest index wins; the loop runs downward so that it does.
    always_comb begin
        victim = '0;
        for (int e = N - 1; e >= 0; e--) begin
            if (oldest[e]) begin
                victim = IW'(e);
            end
        end
    end

    assign err = ~|oldest;

endmodule

// File: rtl/plru_next_state.sv
module plru_next_state #(
    parameter int N  = 4,
    parameter int SW = N * (N - 1) / 2,
    parameter int IW = $clog2(N)
) (
    input  logic [SW-1:0]        state,
    input  logic [N-1:0][SW-1:0] set_m,
    input  logic [N-1:0][SW-1:0] clr_m,
    input  logic                 sw_wr,
    input  logic [SW-1:0]        sw_data,
    input  logic                 refill_valid,
    input  logic                 hit_valid,
    input  logic [IW-1:0]        hit_idx,
    input  logic [IW-1:0]        victim,
    input  logic                 err,
    output plru_pkg::plru_src_e  src,
    output logic [SW-1:0]        nxt
);
    import plru_pkg::*;

    // Pick the transition for this edge.
    always_comb begin
        src = SRC_HOLD;
        if (sw_wr) begin
            src = SRC_SW;
        end else if (refill_valid) begin
            src = err ? SRC_HOLD : SRC_REFILL;
        end else if (hit_valid) begin
            src = SRC_HIT;
        end
    end

    // Build the next state for the chosen transition.
    always_comb begin
        unique case (src)
            SRC_SW:     nxt = sw_data;
            SRC_REFILL: nxt = (state & ~clr_m[victim]) | set_m[victim];
            SRC_HIT:    nxt = (state & ~clr_m[hit_idx]) | set_m[hit_idx];
            default:    nxt = state;
        endcase
    end

endmodule

// File: rtl/plru_tracker.sv
module plru_tracker #(
    parameter int N  = 4,
    parameter int SW = N * (N - 1) / 2,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_valid,
    input  logic [IW-1:0] hit_idx,
    input  logic          refill_valid,
    input  logic          sw_wr,
    input  logic [SW-1:0] sw_data,
    output logic [SW-1:0] lru_state,
    output logic [IW-1:0] victim_idx,
    output logic          state_err
);
    import plru_pkg::*;

    logic [N-1:0][SW-1:0] set_m;
    logic [N-1:0][SW-1:0] clr_m;
    logic [SW-1:0]        state_q;
    logic [SW-1:0]        state_d;
    plru_src_e            src;
    logic [IW-1:0]        victim;
    logic                 err;

    plru_masks #(.N(N), .SW(SW)) u_masks (
        .set_m (set_m),
        .clr_m (clr_m)
    );

    plru_victim_dec #(.N(N), .SW(SW), .IW(IW)) u_dec (
        .state  (state_q),
        .set_m  (set_m),
        .clr_m  (clr_m),
        .victim (victim),
        .err    (err)
    );

    plru_next_state #(.N(N), .SW(SW), .IW(IW)) u_next (
        .state        (state_q),
        .set_m        (set_m),
        .clr_m        (clr_m),
        .sw_wr        (sw_wr),
        .sw_data      (sw_data),
        .refill_valid (refill_valid),
        .hit_valid    (hit_valid),
        .hit_idx      (hit_idx),
        .victim       (victim),
        .err          (err),
        .src          (src),
        .nxt          (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        lru_state  = state_q;
        victim_idx = victim;
        state_err  = err;
    end

endmodule

// File: rtl/plru_tracker_chk.sv
module plru_tracker_chk #(
    parameter int N  = 4,
    parameter int SW = N * (N - 1) / 2,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hit_valid,
    input logic [IW-1:0] hit_idx,
    input logic          refill_valid,
    input logic          sw_wr,
    input logic [SW-1:0] sw_data,
    input logic [SW-1:0] lru_state,
    input logic [IW-1:0] victim_idx,
    input logic          state_err
);
    // R10: a software load lands on the next edge
    a_r10_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> lru_state == $past(sw_data));

    // R11: the state holds when no request is made
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !refill_valid && !hit_valid) |=> $stable(lru_state));

    // R9: a refill in the error state changes nothing
    a_r9_err_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && refill_valid && state_err) |=> $stable(lru_state));

    // R2: a use of entry 0 clears its pair bits and keeps the rest
    a_r2_entry0_use: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !refill_valid && hit_valid && hit_idx == '0)
        |=> (lru_state[SW-1 -: N-1] == '0) &&
            (lru_state[SW-N:0] == $past(lru_state[SW-N:0])));

    // R8: the refilled entry is no longer the victim
    a_r8_refill_moves_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && refill_valid && !state_err)
        |=> (state_err || victim_idx != $past(victim_idx)));

    // R6: the victim reads 0 in the error state
    a_r6_err_victim_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_err |-> victim_idx == '0);

endmodule

bind plru_tracker plru_tracker_chk #(.N(N), .SW(SW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_valid    (hit_valid),
    .hit_idx      (hit_idx),
    .refill_valid (refill_valid),
    .sw_wr        (sw_wr),
    .sw_data      (sw_data),
    .lru_state    (lru_state),
    .victim_idx   (victim_idx),
    .state_err    (state_err)
);

// File: tb/plru_tracker_bench.sv
module plru_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk;
    logic       rst_n;
    logic       hit_valid;
    logic [1:0] hit_idx;
    logic       refill_valid;
    logic       sw_wr;
    logic [5:0] sw_data;
    logic [5:0] lru_state;
    logic [1:0] victim_idx;
    logic       state_err;

    int checks;
    int failures;
    bit done;

    plru_tracker u_plru_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_valid    (hit_valid),
        .hit_idx      (hit_idx),
        .refill_valid (refill_valid),
        .sw_wr        (sw_wr),
        .sw_data      (sw_data),
        .lru_state    (lru_state),
        .victim_idx   (victim_idx),
        .state_err    (state_err)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Update models written bit by bit from R2..R5.
    function automatic logic [5:0] m_touch(input logic [5:0] s, input int e);
        logic [5:0] r;
        r = s;
        case (e)
            0: begin r[5] = 0; r[4] = 0; r[3] = 0; end
            1: begin r[5] = 1; r[2] = 0; r[1] = 0; end
            2: begin r[4] = 1; r[2] = 1; r[0] = 0; end
            default: begin r[3] = 1; r[1] = 1; r[0] = 1; end
        endcase
        return r;
    endfunction

    // Victim model from R6; returns -1 when no pattern matches (R7).
    function automatic int m_victim(input logic [5:0] s);
        if (s[5] && s[4] && s[3]) return 0;
        if (!s[5] && s[2] && s[1]) return 1;
        if (!s[4] && !s[2] && s[0]) return 2;
        if (!s[3] && !s[1] && !s[0]) return 3;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Inputs are driven before a falling edge. One rising edge samples them,
    // and they are cleared at the next falling edge, where results are checked.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        hit_valid    = 0;
        refill_valid = 0;
        sw_wr        = 0;
    endtask

    task automatic load(input logic [5:0] s);
        sw_wr   = 1;
        sw_data = s;
        step();
    endtask

    task automatic check_decode(input logic [5:0] s, input string req);
        int v;
        v = m_victim(s);
        check(state_err == (v < 0), "R7 error flag", int'(state_err), int'(v < 0));
        check(int'(victim_idx) == ((v < 0) ? 0 : v), req, int'(victim_idx), (v < 0) ? 0 : v);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        logic [5:0] s;
        logic [5:0] exp;
        int v;
        checks       = 0;
        failures     = 0;
        done         = 0;
        rst_n        = 0;
        hit_valid    = 0;
        hit_idx      = 0;
        refill_valid = 0;
        sw_wr        = 0;
        sw_data      = 0;

        // R1: reset state
        repeat (2) @(negedge clk);
        check(lru_state == 6'd0, "R1 reset state", int'(lru_state), 0);
        check(victim_idx == 2'd3, "R1 reset victim", int'(victim_idx), 3);
        check(state_err == 1'b0, "R1 reset error", int'(state_err), 0);
        rst_n = 1;
        step();
        check(lru_state == 6'd0, "R1 after release", int'(lru_state), 0);

        // Sweep all states: R10 load, R6/R7 decode, R2..R5 per entry use
        for (int i = 0; i < 64; i++) begin
            s = 6'(i);
            load(s);
            check(lru_state == s, "R10 software load", int'(lru_state), int'(s));
            check_decode(s, "R6 victim decode");
            for (int e = 0; e < 4; e++) begin
                load(s);
                hit_valid = 1;
                hit_idx   = 2'(e);
                step();
                exp = m_touch(s, e);
                case (e)
                    0: check(lru_state == exp, "R2 entry0 use", int'(lru_state), int'(exp));
                    1: check(lru_state == exp, "R3 entry1 use", int'(lru_state), int'(exp));
                    2: check(lru_state == exp, "R4 entry2 use", int'(lru_state), int'(exp));
                    default: check(lru_state == exp, "R5 entry3 use", int'(lru_state), int'(exp));
                endcase
                check_decode(exp, "R12 victim follows state");
            end
            // R8 / R9: refill, with a competing hit on entry (i % 4)
            load(s);
            refill_valid = 1;
            hit_valid    = 1;
            hit_idx      = 2'(i % 4);
            step();
            v = m_victim(s);
            if (v < 0) begin
                check(lru_state == s, "R9 refill in error", int'(lru_state), int'(s));
            end else begin
                exp = m_touch(s, v);
                check(lru_state == exp, "R8 refill update", int'(lru_state), int'(exp));
            end
            // R10: software load overrides a refill and a hit
            load(s);
            sw_wr        = 1;
            sw_data      = ~s;
            refill_valid = 1;
            hit_valid    = 1;
            hit_idx      = 2'((i + 1) % 4);
            step();
            check(lru_state == ~s, "R10 load priority", int'(lru_state), int'(~s));
            // R11: idle cycles hold
            step();
            step();
            check(lru_state == ~s, "R11 idle hold", int'(lru_state), int'(~s));
        end

        // R8: successive refills from reset walk through all four entries
        load(6'd0);
        for (int k = 0; k < 4; k++) begin
            v = int'(victim_idx);
            exp = m_touch(lru_state, v);
            refill_valid = 1;
            step();
            check(lru_state == exp, "R8 refill chain", int'(lru_state), int'(exp));
        end

        finish_run();
    end

endmodule